// File: doc/BRIEF.md
# Minute Time Base from a Mains Tick

This block turns a 60 Hz tick into one short pulse per minute. The tick reaches the block as a squared level, `tick_lvl`. The block synchronizes that level into the system clock domain and treats every high-to-low transition as one count event. A 12-stage binary counter advances by one on each event. A sparse decoder looks at only the counter bits that are set in the terminal value 3600: bits 4, 9, 10 and 11, which weigh 16, 512, 1024 and 2048. When the incremented value has all four of those bits high, the block raises `minute_pulse` for exactly one system clock cycle. On that same clock edge it loads zero into the counter. The cycle therefore repeats every 3600 falling edges.

Every stage is a synchronous flip-flop, so the decode sees a settled value and cannot produce a spike between stages. `count_obs` exposes the counter for observation. An active-high asynchronous reset clears the counter, the synchronizer and the pulse at once. The block has no data stream, so all pins are plain control or status pins and there is no valid/ready handshake.

Top module: `minute_timebase`

## Requirements
- R1: While `rst_async` is high, `count_obs` reads 0 and `minute_pulse` reads 0. Both take these values as soon as reset rises, without waiting for a clock edge.
- R2: Each high-to-low transition of `tick_lvl` adds exactly one to `count_obs`. A rising edge does not change the count, and neither does a level held for any length of time.
- R3: The terminal decode ANDs only the bits of weight 16, 512, 1024 and 2048. Counting up from zero, all four are first high together at 3600, so the pulse comes on the 3600th falling edge after reset or after the previous pulse.
- R4: `minute_pulse` is high for exactly one clock cycle at a time. In that cycle `count_obs` already reads 0.
- R5: `count_obs` stays within the range 0 to 3599.
- R6: Across several consecutive periods, exactly one pulse appears for each 3600 falling edges.
- R7: While no falling edge arrives, `count_obs` holds its value and no pulse appears.
- R8: With the default two synchronizer stages, `count_obs` changes on the third rising clock edge after `tick_lvl` falls. It is unchanged after the second.
- R9: Reset takes priority over a tick. Once reset is released mid-period, no pulse appears until a full 3600 new falling edges have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_async | input | 1 | Active-high asynchronous reset |
| tick_lvl | input | 1 | Squared mains level; each falling edge is one count event |
| minute_pulse | output | 1 | One-cycle pulse each time the count completes |
| count_obs | output | 12 | Current counter value, for observation |

## Verification
A single tick whose edges are timed against the clock shows the synchronizer latency. It separates a design that counts too early or too late from one that counts on the third edge.

Long idle stretches at both input levels, including one very long low phase, separate true falling-edge detection from a design that counts a level or a rising edge.

A run of three full periods separates a decoder that matches at exactly 3600 from one that fires early on a partial bit match, fires late, or fails to clear the counter. A reset placed mid-period checks that the asynchronous clear takes priority and that the next period starts again from zero.

// File: rtl/mtb_pkg.sv
`timescale 1ns/1ps
package mtb_pkg;
  // Default geometry of the minute time base.
  localparam int unsigned MTB_STAGES   = 12;   // binary counter stages
  localparam int unsigned MTB_TERMINAL = 3600; // events per output pulse
  localparam int unsigned MTB_SYNC     = 2;    // synchronizer depth on the tick input
endpackage

// File: rtl/mtb_fall_detect.sv
`timescale 1ns/1ps
// Brings the tick level into the clock domain and flags each falling edge for one cycle.
module mtb_fall_detect #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic fall
);
  logic [SYNC-1:0] sh;
  logic            prev;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk or posedge rst)
        if (rst) sh <= '0;
        else     sh <= lvl_in;
    end else begin : g_many
      always_ff @(posedge clk or posedge rst)
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC-2:0], lvl_in};
    end
  endgenerate

  always_ff @(posedge clk or posedge rst)
    if (rst) prev <= 1'b0;
    else     prev <= sh[SYNC-1];

  assign fall = prev & ~sh[SYNC-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R2
endmodule

// File: rtl/mtb_count_chain.sv
`timescale 1ns/1ps
// Synchronous binary chain: each stage toggles when every lower stage is high.
module mtb_count_chain #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  logic [W-1:0] q_r;
  logic [W-1:0] carry;

  assign carry[0] = adv;

  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      if (i < W - 1) begin : g_carry
        assign carry[i+1] = carry[i] & q_r[i];
      end
      assign q_nxt[i] = q_r[i] ^ carry[i];
      always_ff @(posedge clk or posedge rst)
        if (rst)      q_r[i] <= 1'b0;
        else if (clr) q_r[i] <= 1'b0;
        else          q_r[i] <= q_nxt[i];
    end
  endgenerate

  assign q = q_r;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(q)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (q == $past(q) + 1'b1)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0)); // R4
endmodule

// File: rtl/mtb_sparse_decode.sv
`timescale 1ns/1ps
// Matches only the bits that are set in TERMINAL; the clear bits are don't-care.
module mtb_sparse_decode #(
  parameter int unsigned W        = 12,
  parameter int unsigned TERMINAL = 3600
) (
  input  logic [W-1:0] value,
  output logic         hit
);
  localparam logic [W-1:0] MASK = W'(TERMINAL);
  logic [W-1:0] sel;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_watch
        assign sel[i] = value[i];
      end else begin : g_skip
        assign sel[i] = 1'b1;
      end
    end
  endgenerate

  assign hit = &sel;
endmodule

// File: rtl/minute_timebase.sv
`timescale 1ns/1ps
module minute_timebase
  import mtb_pkg::*;
#(
  parameter int unsigned STAGES   = MTB_STAGES,
  parameter int unsigned TERMINAL = MTB_TERMINAL,
  parameter int unsigned SYNC     = MTB_SYNC
) (
  input  logic              clk,
  input  logic              rst_async,
  input  logic              tick_lvl,
  output logic              minute_pulse,
  output logic [STAGES-1:0] count_obs
);
  localparam logic [STAGES-1:0] LAST = STAGES'(TERMINAL - 1);

  logic              fall;
  logic              hit;
  logic              wrap;
  logic              pulse_q;
  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] cnt_nxt;

  mtb_fall_detect #(.SYNC(SYNC)) u_edge (
    .clk    (clk),
    .rst    (rst_async),
    .lvl_in (tick_lvl),
    .fall   (fall)
  );

  mtb_count_chain #(.W(STAGES)) u_chain (
    .clk   (clk),
    .rst   (rst_async),
    .adv   (fall),
    .clr   (wrap),
    .q     (cnt),
    .q_nxt (cnt_nxt)
  );

  // Decode the incremented value so the reload happens on the terminal event itself.
  mtb_sparse_decode #(.W(STAGES), .TERMINAL(TERMINAL)) u_dec (
    .value (cnt_nxt),
    .hit   (hit)
  );

  assign wrap = fall & hit;

  always_ff @(posedge clk or posedge rst_async)
    if (rst_async) pulse_q <= 1'b0;
    else           pulse_q <= wrap;

  assign minute_pulse = pulse_q;
  assign count_obs    = cnt;

  AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (rst_async)
    minute_pulse |=> !minute_pulse); // R4
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (rst_async)
    minute_pulse |-> (count_obs == '0)); // R4
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst_async)
    count_obs <= LAST); // R5
  AST_PULSE_FROM_LAST: assert property (@(posedge clk) disable iff (rst_async)
    $rose(minute_pulse) |-> ($past(count_obs) == LAST)); // R3
endmodule

// File: tb/test_minute_timebase.sv
`timescale 1ns/1ps
module test_minute_timebase;
  localparam int TERM = 3600;

  logic        clk = 1'b0;
  logic        rst_async = 1'b1;
  logic        tick_lvl = 1'b1;
  logic        minute_pulse;
  logic [11:0] count_obs;

  int total = 0;
  int bad = 0;
  int tick_no = 0;
  int model_cnt = 0;
  int pulses_seen = 0;
  int pushed = 0;
  int range_viol = 0;
  int exp_q[$];
  bit prev_pulse = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  minute_timebase i_minute_timebase (
    .clk          (clk),
    .rst_async    (rst_async),
    .tick_lvl     (tick_lvl),
    .minute_pulse (minute_pulse),
    .count_obs    (count_obs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model step for one falling edge; queues the expected pulse.
  task automatic model_fall();
    tick_no++;
    model_cnt++;
    if (model_cnt == TERM) begin
      model_cnt = 0;
      exp_q.push_back(tick_no);
      pushed++;
    end
  endtask

  task automatic do_tick(input int low_len, input int high_len);
    @(negedge clk);
    tick_lvl = 1'b0;
    model_fall();
    repeat (low_len) @(negedge clk);
    tick_lvl = 1'b1;
    repeat (high_len) @(negedge clk);
    chk(count_obs == 12'(model_cnt), "R2 count after falling edge", count_obs, model_cnt);
  endtask

  // Scoreboard monitor: each pulse pops the expected tick number.
  always @(negedge clk) begin
    if (rst_async) begin
      prev_pulse <= 1'b0;
    end else begin
      if (count_obs > 12'(TERM - 1)) range_viol++;
      if (minute_pulse) begin
        pulses_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected pulse at tick", tick_no, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(e == tick_no, "R3 pulse tick", tick_no, e);
        end
        chk(count_obs == 12'd0, "R4 count zero during pulse", count_obs, 0);
        chk(!prev_pulse, "R4 pulse width one cycle", 2, 1);
      end
      prev_pulse <= minute_pulse;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    // Reset state
    repeat (5) @(negedge clk);
    chk(count_obs == 12'd0, "R1 count in reset", count_obs, 0);
    chk(minute_pulse == 1'b0, "R1 pulse in reset", minute_pulse, 0);
    rst_async = 1'b0;
    repeat (4) @(negedge clk);

    // Latency with two synchronizer stages
    tick_lvl = 1'b0;
    model_fall();
    @(negedge clk);
    @(negedge clk);
    chk(count_obs == 12'd0, "R8 unchanged after second edge", count_obs, 0);
    @(negedge clk);
    chk(count_obs == 12'd1, "R8 changed on third edge", count_obs, 1);
    tick_lvl = 1'b1;
    repeat (4) @(negedge clk);

    // Idle high: no count, no pulse
    p0 = pulses_seen;
    repeat (300) @(negedge clk);
    chk(count_obs == 12'd1, "R7 count held while idle high", count_obs, 1);
    chk(pulses_seen == p0, "R7 no pulse while idle", pulses_seen, p0);

    // Long low phase counts once; rising edge adds nothing
    do_tick(200, 200);
    chk(count_obs == 12'd2, "R2 long low counts once", count_obs, 2);

    // Several full periods
    while (tick_no < 3 * TERM) do_tick(3, 3);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all expected pulses seen", exp_q.size(), 0);
    chk(pulses_seen == 3, "R6 one pulse per 3600 edges", pulses_seen, 3);
    chk(count_obs == 12'd0, "R6 count at period boundary", count_obs, 0);

    // Mid-period asynchronous reset
    for (int k = 0; k < 1000; k++) do_tick(3, 3);
    @(negedge clk);
    #3 rst_async = 1'b1;
    #2 chk(count_obs == 12'd0, "R1 asynchronous clear before clock edge", count_obs, 0);
    chk(exp_q.size() == 0, "R9 nothing pending at reset", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    rst_async = 1'b0;
    tick_no = 0;
    model_cnt = 0;
    p0 = pulses_seen;
    for (int k = 0; k < TERM - 1; k++) do_tick(3, 3);
    chk(pulses_seen == p0, "R9 no pulse before full period", pulses_seen, p0);
    chk(count_obs == 12'(TERM - 1), "R5 count reaches top value", count_obs, TERM - 1);
    do_tick(3, 3);
    chk(pulses_seen == p0 + 1, "R9 pulse after full period", pulses_seen, p0 + 1);
    chk(pulses_seen == pushed, "R6 total pulse count", pulses_seen, pushed);
    chk(range_viol == 0, "R5 count never above 3599", range_viol, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule